// File: doc/BRIEF.md
# Dual-Issue Pairing Gate

This block sits in the issue stage of an in-order pipeline that can start two instructions per cycle. Each cycle it receives decoded descriptors for the two oldest instructions, the older in slot A and the younger in slot B. It decides whether both may start together (pair) or only the older one (single). A descriptor holds a class code, a destination register and two source registers with their use flags, and FP-memory, store and single-word flags. It also holds a half select for single-word access to a doubleword register, carry-set and carry-use flags, the low bit of the word address, and a flag marking an instruction reached as the target of a taken branch.

The pairing decision starts from an ordered table. The table lists which class may follow which class, and it is not symmetric. On top of that table the block applies several exclusions: register dependences, FP half-register and same-target conflicts, carry flag producer/consumer pairs, odd-address branch targets, and branch delay slots. There is one exception: a flop may pair with a following FP store of its own result. A single register remembers whether the next older instruction sits in a branch delay slot. Register numbers share one namespace.

Top module: `pair_issue_gate`

## Requirements
- R1: Class codes are flop=0, ldst=1, flex=2, mm=3, nul=4, bv=5, br=6, fsys=7, sys=8. With no other exclusion active, a pair issues exactly when the younger class appears in the older class's list. The lists are: flop→{ldst,flex,mm,nul,bv,br}, ldst→{flop,flex,mm,nul,br}, flex→{flop,ldst,flex,mm,nul,br,fsys}, mm→{flop,ldst,flex,fsys}, nul→{flop}. So a may-nullify instruction pairs only with a following flop.
- R2: A sys instruction in either slot never pairs, and neither do codes 9 to 15.
- R3: An older instruction of class bv, br or fsys always issues single.
- R4: Two ldst instructions pair only while `dword_ok` is 1.
- R5: The pair is refused when A writes (`a_wr`) a register that B reads through a source whose use flag is set. This applies to `b_src0` with `b_rd0` and to `b_src1` with `b_rd1`.
- R6: A flop A paired with an FP store B (ldst, `b_fpmem`=1, `b_store`=1) is allowed when only the store's data register `b_src1` matches A's destination. A match on the address register `b_src0` still refuses the pair.
- R7: An FP load (ldst, fpmem, not store, writing, single-word) to register R with half h is not paired with a single-word flop that reads R in half !h.
- R8: A writing flop and an FP load with the same destination register are not paired, in either order.
- R9: A carry-setting instruction is not paired with a carry-using one, in either order.
- R10: If either slot has both `*_tgt`=1 and `*_odd`=1, the pair is refused.
- R11: `in_dslot` goes to 1 after a cycle whose last issued instruction is bv or br. That instruction is A when single, and B when paired. It goes to 0 after any other issue and holds while `a_valid` is 0. While it is 1, the older instruction issues single.
- R12: With `a_valid`=0 neither output is 1. With `a_valid`=1 exactly one of `issue_pair` and `issue_single` is 1, and `issue_pair` needs `b_valid`=1.
- R13: Reset, active low, clears `in_dslot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| dword_ok | input | 1 | double-word load/store condition holds |
| a_valid | input | 1 | slot A (older) valid |
| a_cls | input | 4 | slot A class code |
| a_dst | input | REG_W | slot A destination |
| a_src0 | input | REG_W | slot A source 0 (address for memory ops) |
| a_src1 | input | REG_W | slot A source 1 (store data) |
| a_rd0 | input | 1 | slot A reads source 0 |
| a_rd1 | input | 1 | slot A reads source 1 |
| a_wr | input | 1 | slot A writes destination |
| a_fpmem | input | 1 | slot A is an FP memory access |
| a_store | input | 1 | slot A is a store |
| a_single | input | 1 | slot A uses one word of a doubleword register |
| a_half | input | 1 | slot A word select |
| a_cset | input | 1 | slot A may set carry/borrow |
| a_cuse | input | 1 | slot A reads carry/borrow |
| a_odd | input | 1 | slot A word address is odd |
| a_tgt | input | 1 | slot A reached by a taken branch |
| b_valid | input | 1 | slot B (younger) valid |
| b_cls | input | 4 | slot B class code |
| b_dst | input | REG_W | slot B destination |
| b_src0 | input | REG_W | slot B source 0 |
| b_src1 | input | REG_W | slot B source 1 |
| b_rd0 | input | 1 | slot B reads source 0 |
| b_rd1 | input | 1 | slot B reads source 1 |
| b_wr | input | 1 | slot B writes destination |
| b_fpmem | input | 1 | slot B is an FP memory access |
| b_store | input | 1 | slot B is a store |
| b_single | input | 1 | slot B single-word |
| b_half | input | 1 | slot B word select |
| b_cset | input | 1 | slot B may set carry/borrow |
| b_cuse | input | 1 | slot B reads carry/borrow |
| b_odd | input | 1 | slot B word address is odd |
| b_tgt | input | 1 | slot B reached by a taken branch |
| issue_pair | output | 1 | both slots issue |
| issue_single | output | 1 | only slot A issues |
| in_dslot | output | 1 | older instruction is in a branch delay slot |

## Verification
The hardest state to reach is the delay-slot register meeting a pair that would otherwise be legal. Reaching it takes a branch issuing first, either alone or behind a flop. The stimulus then holds slot A idle for a cycle to show the state is retained, and only after that presents a clean flex/flex pair, which must be split. The FP store exception is also subtle. The bench runs it with the match on the data register and then on the address register, and repeats it with a non-flop producer, so that a too-wide exception is caught.

// File: rtl/pig_pkg.sv
package pig_pkg;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned NCLS     = 9;
  localparam int unsigned DATA_SRC = 1;

  typedef enum logic [3:0] {
    C_FLOP = 4'd0, C_LDST = 4'd1, C_FLEX = 4'd2, C_MM   = 4'd3,
    C_NUL  = 4'd4, C_BV   = 4'd5, C_BR   = 4'd6, C_FSYS = 4'd7,
    C_SYS  = 4'd8
  } cls_e;

  typedef struct packed {
    cls_e                       cls;
    logic [REG_W-1:0]           dst;
    logic [NSRC-1:0][REG_W-1:0] src;
    logic [NSRC-1:0]            rd;
    logic                       wr;
    logic                       fpmem;
    logic                       store;
    logic                       single;
    logic                       half;
    logic                       cset;
    logic                       cuse;
    logic                       odd;
    logic                       tgt;
  } desc_t;

  function automatic logic [NCLS-1:0] cbit(cls_e c);
    return (NCLS)'(1) << c;
  endfunction

  // classes allowed in the younger slot behind a given older class
  function automatic logic [NCLS-1:0] follow_set(cls_e c);
    case (c)
      C_FLOP: return cbit(C_LDST) | cbit(C_FLEX) | cbit(C_MM) | cbit(C_NUL)
                   | cbit(C_BV) | cbit(C_BR);
      C_LDST: return cbit(C_FLOP) | cbit(C_FLEX) | cbit(C_MM) | cbit(C_NUL)
                   | cbit(C_BR);
      C_FLEX: return cbit(C_FLOP) | cbit(C_LDST) | cbit(C_FLEX) | cbit(C_MM)
                   | cbit(C_NUL) | cbit(C_BR) | cbit(C_FSYS);
      C_MM:   return cbit(C_FLOP) | cbit(C_LDST) | cbit(C_FLEX) | cbit(C_FSYS);
      C_NUL:  return cbit(C_FLOP);
      default: return '0;
    endcase
  endfunction

  function automatic logic is_branch(cls_e c);
    return (c == C_BV) || (c == C_BR);
  endfunction

  function automatic logic is_fp_load(desc_t d);
    return (d.cls == C_LDST) && d.fpmem && !d.store && d.wr;
  endfunction

  function automatic logic is_fp_store(desc_t d);
    return (d.cls == C_LDST) && d.fpmem && d.store;
  endfunction

  // flop reading the opposite word of a register an FP load fills
  function automatic logic half_clash(desc_t ld, desc_t fl);
    logic hit;
    hit = 1'b0;
    if (is_fp_load(ld) && ld.single && fl.cls == C_FLOP && fl.single &&
        fl.half != ld.half)
      for (int j = 0; j < NSRC; j++)
        if (fl.rd[j] && fl.src[j] == ld.dst) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic same_target(desc_t fl, desc_t ld);
    return (fl.cls == C_FLOP) && fl.wr && is_fp_load(ld) && (fl.dst == ld.dst);
  endfunction
endpackage

// File: rtl/pig_class_gate.sv
module pig_class_gate
  import pig_pkg::*;
(
  input  cls_e first,
  input  cls_e second,
  input  logic dword_ok,
  output logic class_ok
);
  logic [NCLS-1:0] first_hot, second_hot, row_ok;

  for (genvar r = 0; r < NCLS; r++) begin : g_row
    logic [NCLS-1:0] row_mask;
    assign first_hot[r]  = (first  == cls_e'(4'(r)));
    assign second_hot[r] = (second == cls_e'(4'(r)));
    assign row_mask      = follow_set(cls_e'(4'(r)));
    assign row_ok[r]     = first_hot[r] && |(row_mask & second_hot);
  end

  logic dword_pair;
  assign dword_pair = first_hot[C_LDST] && second_hot[C_LDST] && dword_ok;
  assign class_ok   = (|row_ok) || dword_pair;
endmodule

// File: rtl/pig_hazard.sv
module pig_hazard
  import pig_pkg::*;
(
  input  desc_t a,
  input  desc_t b,
  output logic  raw_hit,
  output logic  half_hit,
  output logic  tgt_hit,
  output logic  carry_hit,
  output logic  odd_hit
);
  logic store_fwd;
  assign store_fwd = (a.cls == C_FLOP) && is_fp_store(b);

  logic [NSRC-1:0] src_hit, exempt;
  for (genvar j = 0; j < NSRC; j++) begin : g_src
    assign src_hit[j] = a.wr && b.rd[j] && (b.src[j] == a.dst);
    if (j == DATA_SRC) begin : g_data
      assign exempt[j] = store_fwd;
    end else begin : g_addr
      assign exempt[j] = 1'b0;
    end
  end
  assign raw_hit = |(src_hit & ~exempt);

  // ordering 0: load older, flop younger; ordering 1: the reverse
  logic [1:0] half_ord, tgt_ord;
  for (genvar k = 0; k < 2; k++) begin : g_ord
    desc_t ld, fl;
    assign ld          = (k == 0) ? a : b;
    assign fl          = (k == 0) ? b : a;
    assign half_ord[k] = half_clash(ld, fl);
    assign tgt_ord[k]  = same_target(fl, ld);
  end
  assign half_hit  = |half_ord;
  assign tgt_hit   = |tgt_ord;
  assign carry_hit = (a.cset && b.cuse) || (b.cset && a.cuse);
  assign odd_hit   = (a.tgt && a.odd) || (b.tgt && b.odd);
endmodule

// File: rtl/pig_slot_track.sv
module pig_slot_track
  import pig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_valid,
  input  logic pair_go,
  input  cls_e a_cls,
  input  cls_e b_cls,
  output logic dslot
);
  logic last_branch;
  assign last_branch = pair_go ? is_branch(b_cls) : is_branch(a_cls);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dslot <= 1'b0;
    else if (a_valid) dslot <= last_branch;
  end
endmodule

// File: rtl/pair_issue_gate.sv
module pair_issue_gate
  import pig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dword_ok,
  input  logic             a_valid,
  input  logic [3:0]       a_cls,
  input  logic [REG_W-1:0] a_dst,
  input  logic [REG_W-1:0] a_src0,
  input  logic [REG_W-1:0] a_src1,
  input  logic             a_rd0,
  input  logic             a_rd1,
  input  logic             a_wr,
  input  logic             a_fpmem,
  input  logic             a_store,
  input  logic             a_single,
  input  logic             a_half,
  input  logic             a_cset,
  input  logic             a_cuse,
  input  logic             a_odd,
  input  logic             a_tgt,
  input  logic             b_valid,
  input  logic [3:0]       b_cls,
  input  logic [REG_W-1:0] b_dst,
  input  logic [REG_W-1:0] b_src0,
  input  logic [REG_W-1:0] b_src1,
  input  logic             b_rd0,
  input  logic             b_rd1,
  input  logic             b_wr,
  input  logic             b_fpmem,
  input  logic             b_store,
  input  logic             b_single,
  input  logic             b_half,
  input  logic             b_cset,
  input  logic             b_cuse,
  input  logic             b_odd,
  input  logic             b_tgt,
  output logic             issue_pair,
  output logic             issue_single,
  output logic             in_dslot
);
  desc_t da, db;
  assign da = '{cls: cls_e'(a_cls), dst: a_dst, src: {a_src1, a_src0},
                rd: {a_rd1, a_rd0}, wr: a_wr, fpmem: a_fpmem, store: a_store,
                single: a_single, half: a_half, cset: a_cset, cuse: a_cuse,
                odd: a_odd, tgt: a_tgt};
  assign db = '{cls: cls_e'(b_cls), dst: b_dst, src: {b_src1, b_src0},
                rd: {b_rd1, b_rd0}, wr: b_wr, fpmem: b_fpmem, store: b_store,
                single: b_single, half: b_half, cset: b_cset, cuse: b_cuse,
                odd: b_odd, tgt: b_tgt};

  logic class_ok, raw_hit, half_hit, tgt_hit, carry_hit, odd_hit;

  pig_class_gate u_cls (
    .first(da.cls), .second(db.cls), .dword_ok(dword_ok), .class_ok(class_ok)
  );

  pig_hazard u_hz (
    .a(da), .b(db), .raw_hit(raw_hit), .half_hit(half_hit),
    .tgt_hit(tgt_hit), .carry_hit(carry_hit), .odd_hit(odd_hit)
  );

  logic blocked;
  assign blocked = raw_hit || half_hit || tgt_hit || carry_hit || odd_hit;

  assign issue_pair   = a_valid && b_valid && !in_dslot && class_ok && !blocked;
  assign issue_single = a_valid && !issue_pair;

  pig_slot_track u_trk (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .pair_go(issue_pair),
    .a_cls(da.cls), .b_cls(db.cls), .dslot(in_dslot)
  );
endmodule

// File: rtl/pig_chk.sv
module pig_chk
  import pig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       a_valid,
  input logic       b_valid,
  input logic [3:0] a_cls,
  input logic [3:0] b_cls,
  input logic       a_cset,
  input logic       a_cuse,
  input logic       b_cset,
  input logic       b_cuse,
  input logic       a_odd,
  input logic       a_tgt,
  input logic       b_odd,
  input logic       b_tgt,
  input logic       raw_hit,
  input logic       issue_pair,
  input logic       issue_single,
  input logic       in_dslot
);
  logic a_br, b_br;
  assign a_br = (a_cls == C_BV) || (a_cls == C_BR);
  assign b_br = (b_cls == C_BV) || (b_cls == C_BR);

  // R12
  issue_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_pair && issue_single));
  // R12
  older_issues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> (issue_pair || issue_single));
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> (!issue_pair && !issue_single));
  // R12
  pair_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> b_valid);
  // R2
  sys_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> (a_cls < 4'd8 && b_cls < 4'd8));
  // R3
  first_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> !(a_br || a_cls == C_FSYS));
  // R5
  raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> !raw_hit);
  // R9
  carry_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> !((a_cset && b_cuse) || (b_cset && a_cuse)));
  // R10
  odd_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pair |-> !((a_tgt && a_odd) || (b_tgt && b_odd)));
  // R11
  dslot_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_dslot |-> !issue_pair);
  // R11
  dslot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_single && a_br) || (issue_pair && b_br)) |=> in_dslot);
  // R11
  dslot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_single && !a_br) || (issue_pair && !b_br)) |=> !in_dslot);
  // R11
  dslot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |=> $stable(in_dslot));
endmodule

bind pair_issue_gate pig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .b_valid(b_valid),
  .a_cls(a_cls), .b_cls(b_cls), .a_cset(a_cset), .a_cuse(a_cuse),
  .b_cset(b_cset), .b_cuse(b_cuse), .a_odd(a_odd), .a_tgt(a_tgt),
  .b_odd(b_odd), .b_tgt(b_tgt), .raw_hit(raw_hit),
  .issue_pair(issue_pair), .issue_single(issue_single), .in_dslot(in_dslot)
);

// File: tb/sim_pair_issue_gate.sv
`timescale 1ns/1ps
module sim_pair_issue_gate;
  import pig_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic dword_ok;
  logic a_valid, a_rd0, a_rd1, a_wr, a_fpmem, a_store, a_single, a_half;
  logic a_cset, a_cuse, a_odd, a_tgt;
  logic b_valid, b_rd0, b_rd1, b_wr, b_fpmem, b_store, b_single, b_half;
  logic b_cset, b_cuse, b_odd, b_tgt;
  logic [3:0] a_cls, b_cls;
  logic [REG_W-1:0] a_dst, a_src0, a_src1, b_dst, b_src0, b_src1;
  logic issue_pair, issue_single, in_dslot;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  pair_issue_gate u0 (.*);

  // allowed younger classes per older class, bit = younger class code (R1)
  localparam logic [8:0] ALLOW [9] = '{
    9'b001111110, 9'b001011101, 9'b011011111, 9'b010000111, 9'b000000001,
    9'b000000000, 9'b000000000, 9'b000000000, 9'b000000000 };

  task automatic neutral();
    dword_ok = 0;
    a_valid = 0; a_cls = 4'd2; a_dst = '0; a_src0 = '0; a_src1 = '0;
    a_rd0 = 0; a_rd1 = 0; a_wr = 0; a_fpmem = 0; a_store = 0; a_single = 0;
    a_half = 0; a_cset = 0; a_cuse = 0; a_odd = 0; a_tgt = 0;
    b_valid = 0; b_cls = 4'd2; b_dst = '0; b_src0 = '0; b_src1 = '0;
    b_rd0 = 0; b_rd1 = 0; b_wr = 0; b_fpmem = 0; b_store = 0; b_single = 0;
    b_half = 0; b_cset = 0; b_cuse = 0; b_odd = 0; b_tgt = 0;
  endtask

  task automatic both(input logic [3:0] fc, input logic [3:0] sc);
    neutral();
    a_valid = 1; b_valid = 1; a_cls = fc; b_cls = sc;
  endtask

  task automatic look(input string req, input logic ep, input logic es);
    #1;
    nchk++;
    if (issue_pair !== ep || issue_single !== es) begin
      nfail++;
      $display("FAIL %s: pair,single=%b,%b expected %b,%b", req,
               issue_pair, issue_single, ep, es);
    end
    @(posedge clk); #1;
  endtask

  task automatic see_ds(input string req, input logic e);
    nchk++;
    if (in_dslot !== e) begin
      nfail++;
      $display("FAIL %s: in_dslot=%b expected %b", req, in_dslot, e);
    end
  endtask

  task automatic flush();
    neutral(); a_valid = 1;
    #1; @(posedge clk); #1;
    neutral();
  endtask

  initial begin
    neutral();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    see_ds("R13", 1'b0);
    rst_n = 1;
    @(posedge clk); #1;

    // R12 valid handling
    neutral(); look("R12", 0, 0);
    neutral(); a_valid = 1; look("R12", 0, 1);
    both(4'd2, 4'd2); b_valid = 0; look("R12", 0, 1);

    // R1 / R3 whole class table
    for (int f = 0; f < 9; f++)
      for (int s = 0; s < 9; s++) begin
        flush();
        both(4'(f), 4'(s));
        look(((f >= 5 && f <= 7) ? "R3" : "R1"), ALLOW[f][s], !ALLOW[f][s]);
      end

    // R2 unused codes never pair
    for (int c = 9; c < 16; c++) begin
      flush(); both(4'd2, 4'(c)); look("R2", 0, 1);
      flush(); both(4'(c), 4'd2); look("R2", 0, 1);
    end

    // R4 double-word ldst pair
    flush(); both(4'd1, 4'd1); dword_ok = 1; look("R4", 1, 0);
    flush(); both(4'd2, 4'd2); dword_ok = 1; look("R4", 1, 0);

    // R5 register dependence
    flush(); both(4'd2, 4'd2); a_wr = 1; a_dst = 5'd3; b_rd0 = 1; b_src0 = 5'd3;
    look("R5", 0, 1);
    flush(); both(4'd2, 4'd2); a_wr = 1; a_dst = 5'd3; b_rd1 = 1; b_src1 = 5'd3;
    look("R5", 0, 1);
    flush(); both(4'd2, 4'd2); a_wr = 1; a_dst = 5'd3; b_src0 = 5'd3;
    look("R5", 1, 0);
    flush(); both(4'd2, 4'd2); a_dst = 5'd3; b_rd0 = 1; b_src0 = 5'd3;
    look("R5", 1, 0);

    // R6 flop then FP store of its result
    flush(); both(4'd0, 4'd1); a_wr = 1; a_dst = 5'd4;
    b_fpmem = 1; b_store = 1; b_rd0 = 1; b_src0 = 5'd9; b_rd1 = 1; b_src1 = 5'd4;
    look("R6", 1, 0);
    flush(); both(4'd0, 4'd1); a_wr = 1; a_dst = 5'd4;
    b_fpmem = 1; b_store = 1; b_rd0 = 1; b_src0 = 5'd4; b_rd1 = 1; b_src1 = 5'd7;
    look("R6", 0, 1);
    flush(); both(4'd2, 4'd1); a_wr = 1; a_dst = 5'd4;
    b_fpmem = 1; b_store = 1; b_rd0 = 1; b_src0 = 5'd9; b_rd1 = 1; b_src1 = 5'd4;
    look("R6", 0, 1);

    // R7 half-register clash, flop older
    flush(); both(4'd0, 4'd1); a_wr = 1; a_dst = 5'd10; a_rd0 = 1; a_src0 = 5'd6;
    a_single = 1; a_half = 0; b_fpmem = 1; b_wr = 1; b_dst = 5'd6; b_single = 1;
    b_half = 1;
    look("R7", 0, 1);
    flush(); both(4'd0, 4'd1); a_wr = 1; a_dst = 5'd10; a_rd0 = 1; a_src0 = 5'd6;
    a_single = 1; a_half = 0; b_fpmem = 1; b_wr = 1; b_dst = 5'd6; b_single = 1;
    b_half = 0;
    look("R7", 1, 0);

    // R8 same target
    flush(); both(4'd0, 4'd1); a_wr = 1; a_dst = 5'd7; b_fpmem = 1; b_wr = 1;
    b_dst = 5'd7;
    look("R8", 0, 1);
    flush(); both(4'd1, 4'd0); a_fpmem = 1; a_wr = 1; a_dst = 5'd7; b_wr = 1;
    b_dst = 5'd7;
    look("R8", 0, 1);
    flush(); both(4'd0, 4'd1); a_wr = 1; a_dst = 5'd7; b_fpmem = 1; b_wr = 1;
    b_dst = 5'd8;
    look("R8", 1, 0);

    // R9 carry
    flush(); both(4'd2, 4'd2); a_cset = 1; b_cuse = 1; look("R9", 0, 1);
    flush(); both(4'd2, 4'd2); b_cset = 1; a_cuse = 1; look("R9", 0, 1);
    flush(); both(4'd2, 4'd2); a_cset = 1; b_cset = 1; look("R9", 1, 0);

    // R10 odd-address branch target
    flush(); both(4'd2, 4'd2); a_odd = 1; a_tgt = 1; look("R10", 0, 1);
    flush(); both(4'd2, 4'd2); b_odd = 1; b_tgt = 1; look("R10", 0, 1);
    flush(); both(4'd2, 4'd2); a_odd = 1; look("R10", 1, 0);
    flush(); both(4'd2, 4'd2); a_tgt = 1; look("R10", 1, 0);

    // R11 delay slot
    flush(); both(4'd6, 4'd2); look("R11", 0, 1);
    see_ds("R11", 1);
    neutral(); look("R12", 0, 0);
    see_ds("R11", 1);
    both(4'd2, 4'd2); look("R11", 0, 1);
    see_ds("R11", 0);
    both(4'd2, 4'd2); look("R11", 1, 0);
    both(4'd0, 4'd5); look("R11", 1, 0);
    see_ds("R11", 1);
    both(4'd2, 4'd2); look("R11", 0, 1);

    // R13 reset clears a set delay slot
    flush(); both(4'd5, 4'd2); look("R11", 0, 1);
    see_ds("R11", 1);
    neutral(); rst_n = 0;
    @(posedge clk); #1;
    see_ds("R13", 0);
    rst_n = 1;
    @(posedge clk); #1;

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule